// File: doc/BRIEF.md
# Endpoint Loopback Client

This block is user logic that sits on a byte-wide, packet-level endpoint port of a USB device packet engine. All of its signals run on the engine's 60 MHz clock. Packets that the host sends to the receive endpoint (number 1) are written into one of two packet buffers. Buffers that hold a packet are queued, and their contents go back to the host as IN packets on the transmit endpoint (number 4) in the order they arrived.

The engine raises `hw_active` at the start of every transaction and presents the endpoint number on `hw_ep`. On each clock where `hw_next` is high, the engine either takes a received byte or consumes a transmit byte. When the engine drops `hw_active`, `hw_error` reports the outcome of the transaction. The block decides whether to accept each transaction with `hw_ready` and refuses unknown endpoints with `hw_stall`. It drops the two CRC bytes that end every received packet and discards a received packet that failed its check. It keeps a transmitted packet until the host has taken it without error, so a failed send is repeated on the next IN transaction.

Top module: `ep_loopback`

## Requirements
- R1: While reset is high and on the first clock after it, `hw_ready` and `hw_stall` are low.
- R2: When `hw_active` rises for endpoint 1 and a buffer is free, or for endpoint 4 and a packet is queued, `hw_ready` is high on the next clock.
- R3: On a receive, the block stores every byte taken on a `hw_next`-high clock except the last two, and the stored length is the byte count minus 2. On a good receive, `hw_ready` is low on the clock after `hw_active` falls.
- R4: A receive that ends with `hw_error` high stores nothing. The queue and later IN packets are unchanged.
- R5: When both buffers hold packets, an endpoint-1 transaction sees `hw_ready` low for its whole duration, and the packet is not stored.
- R6: When no packet is queued, an endpoint-4 transaction sees `hw_ready` low.
- R7: During a transmit, byte 0 of the packet is on `hw_tx_data` before the first `hw_next`. Each `hw_next`-high clock moves the output to the following byte on the next clock. `hw_ready` goes low on the clock after the `hw_next` of the last byte.
- R8: A zero-length packet, which comes from a receive of only the two CRC bytes, is sent by holding `hw_ready` high for exactly one clock, with no bytes.
- R9: If `hw_active` falls with `hw_error` high after a transmit, the same packet is sent again on the next endpoint-4 transaction. A buffer is released only after a transmit completes without error.
- R10: For any endpoint other than 1 and 4, `hw_stall` is high from the clock after `hw_active` rises until the clock after it falls, and `hw_ready` stays low. `hw_ready` and `hw_stall` are never high together.
- R11: Queued packets are transmitted in the order they were received.
- R12: Packets with a payload of up to 512 bytes, the bulk maximum, are stored and returned intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 60 MHz port clock |
| rst | input | 1 | Synchronous reset, active high |
| hw_active | input | 1 | Transaction in progress |
| hw_next | input | 1 | Byte transfer strobe |
| hw_error | input | 1 | Failed transaction, valid as hw_active falls |
| hw_ep | input | 4 | Endpoint number, valid while hw_active is high |
| hw_rx_data | input | 8 | Received byte |
| hw_ready | output | 1 | Endpoint accepts the transaction |
| hw_stall | output | 1 | Endpoint refuses the transaction |
| hw_tx_data | output | 8 | Byte to transmit |

## Verification
The assertions assume the engine keeps to its own protocol. Only one transaction is in progress at a time. `hw_next` is high only while `hw_active` and `hw_ready` are both high. `hw_error` is high only on the clock where `hw_active` falls. On a receive, the engine delivers no more than the maximum payload plus two bytes. The bench's engine model follows all of these rules: it waits for `hw_ready` before it strobes, it releases `hw_next` before it lowers `hw_active`, and it keeps `hw_error` high for one clock only. With these inputs, the buffer occupancy and the ready/stall handshake can be checked as invariants.

// File: rtl/ep_lb_pkg.sv
package ep_lb_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_RX, S_TX, S_TXW, S_HOLD
  } lb_state_t;
endpackage

// File: rtl/ep_lb_store.sv
module ep_lb_store #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  localparam int DEPTH = 1 << AW;
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/ep_lb_ring.sv
module ep_lb_ring #(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  input  logic [CW-1:0] len_in,
  output logic          wsel,
  output logic          rsel,
  output logic [CW-1:0] head_len,
  output logic [1:0]    count
);
  logic [CW-1:0] len_q [2];

  always_ff @(posedge clk) begin
    if (rst) begin
      wsel  <= 1'b0;
      rsel  <= 1'b0;
      count <= 2'd0;
    end else begin
      if (push) begin
        len_q[wsel] <= len_in;
        wsel        <= ~wsel;
      end
      if (pop) rsel <= ~rsel;
      case ({push, pop})
        2'b10:   count <= count + 2'd1;
        2'b01:   count <= count - 2'd1;
        default: count <= count;
      endcase
    end
  end

  assign head_len = len_q[rsel];

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
    push |-> (count != 2'd2));
  assert_no_underflow_R9: assert property (@(posedge clk) disable iff (rst)
    pop |-> (count != 2'd0));
  assert_single_op_R11: assert property (@(posedge clk) disable iff (rst)
    !(push && pop));
endmodule

// File: rtl/ep_loopback.sv
module ep_loopback #(
  parameter int          MAX_PKT = 512,
  parameter logic [3:0]  RX_EP   = 4'd1,
  parameter logic [3:0]  TX_EP   = 4'd4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       hw_active,
  input  logic       hw_next,
  input  logic       hw_error,
  input  logic [3:0] hw_ep,
  input  logic [7:0] hw_rx_data,
  output logic       hw_ready,
  output logic       hw_stall,
  output logic [7:0] hw_tx_data
);
  import ep_lb_pkg::*;

  localparam int AW      = $clog2(MAX_PKT);
  localparam int CW      = $clog2(MAX_PKT + 3);
  localparam logic [CW-1:0] CNT_MAX = CW'(MAX_PKT + 2);
  localparam logic [CW-1:0] PKT_LIM = CW'(MAX_PKT);

  lb_state_t     state;
  logic          act_q;
  logic [CW-1:0] wr_ptr, rd_ptr;
  logic          wsel, rsel;
  logic [CW-1:0] head_len, len_in;
  logic [1:0]    count;
  logic          push, pop, we, rise;
  logic [CW-1:0] rd_idx;

  assign rise   = hw_active && !act_q;
  assign push   = (state == S_RX)  && !hw_active && !hw_error;
  assign pop    = (state == S_TXW) && !hw_active && !hw_error;
  assign len_in = (wr_ptr >= CW'(2)) ? wr_ptr - CW'(2) : '0;
  assign we     = (state == S_RX) && hw_active && hw_next && (wr_ptr < PKT_LIM);
  assign rd_idx = ((state == S_TX) && hw_next) ? rd_ptr + CW'(1) : rd_ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      act_q    <= 1'b0;
      hw_ready <= 1'b0;
      hw_stall <= 1'b0;
      wr_ptr   <= '0;
      rd_ptr   <= '0;
    end else begin
      act_q <= hw_active;
      case (state)
        S_IDLE: begin
          wr_ptr <= '0;
          rd_ptr <= '0;
          if (rise) begin
            if (hw_ep == RX_EP) begin
              if (count != 2'd2) begin hw_ready <= 1'b1; state <= S_RX; end
              else state <= S_HOLD;
            end else if (hw_ep == TX_EP) begin
              if (count != 2'd0) begin hw_ready <= 1'b1; state <= S_TX; end
              else state <= S_HOLD;
            end else begin
              hw_stall <= 1'b1;
              state    <= S_HOLD;
            end
          end
        end
        S_RX: begin
          if (!hw_active) begin
            hw_ready <= 1'b0;
            state    <= S_IDLE;
          end else if (hw_next && wr_ptr != CNT_MAX) begin
            wr_ptr <= wr_ptr + CW'(1);
          end
        end
        S_TX: begin
          if (!hw_active) begin
            hw_ready <= 1'b0;
            state    <= S_IDLE;
          end else if (head_len == '0) begin
            hw_ready <= 1'b0;
            state    <= S_TXW;
          end else if (hw_next) begin
            rd_ptr <= rd_ptr + CW'(1);
            if (rd_ptr == head_len - CW'(1)) begin
              hw_ready <= 1'b0;
              state    <= S_TXW;
            end
          end
        end
        S_TXW: if (!hw_active) state <= S_IDLE;
        S_HOLD: begin
          if (!hw_active) begin
            hw_stall <= 1'b0;
            state    <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  ep_lb_ring #(.CW(CW)) ring_i (
    .clk(clk), .rst(rst), .push(push), .pop(pop), .len_in(len_in),
    .wsel(wsel), .rsel(rsel), .head_len(head_len), .count(count)
  );

  ep_lb_store #(.AW(AW + 1)) store_i (
    .clk(clk), .we(we),
    .waddr({wsel, wr_ptr[AW-1:0]}), .wdata(hw_rx_data),
    .raddr({rsel, rd_idx[AW-1:0]}), .rdata(hw_tx_data)
  );

  assert_ready_stall_excl_R10: assert property (@(posedge clk) disable iff (rst)
    !(hw_ready && hw_stall));
  assert_ready_needs_active_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(hw_ready) |-> $past(hw_active));
  assert_rx_has_room_R5: assert property (@(posedge clk) disable iff (rst)
    (state == S_RX) |-> (count != 2'd2));
  assert_tx_has_pkt_R6: assert property (@(posedge clk) disable iff (rst)
    (state == S_TX) |-> (count != 2'd0));
endmodule

// File: tb/ep_loopback_tb_top.sv
module ep_loopback_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hw_active = 1'b0, hw_next = 1'b0, hw_error = 1'b0;
  logic [3:0] hw_ep = 4'd0;
  logic [7:0] hw_rx_data = 8'd0;
  logic hw_ready, hw_stall;
  logic [7:0] hw_tx_data;

  int checks = 0;
  int failures = 0;
  int m_seed [2];
  int m_len  [2];
  int m_head = 0;
  int m_cnt  = 0;

  always #10 clk = ~clk;

  ep_loopback dut_i (
    .clk(clk), .rst(rst), .hw_active(hw_active), .hw_next(hw_next),
    .hw_error(hw_error), .hw_ep(hw_ep), .hw_rx_data(hw_rx_data),
    .hw_ready(hw_ready), .hw_stall(hw_stall), .hw_tx_data(hw_tx_data)
  );

  function automatic logic [7:0] pat(int s, int i);
    return 8'((s * 37) + (i * 11) + (i >> 3));
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_rx(int n, int seed, bit bad, bit expect_ok, string req);
    @(negedge clk); hw_ep = 4'd1; hw_active = 1'b1;
    @(negedge clk);
    check(hw_ready == expect_ok, req, int'(hw_ready), int'(expect_ok));
    if (expect_ok) begin
      for (int i = 0; i < n + 2; i++) begin
        hw_next = 1'b1;
        hw_rx_data = (i < n) ? pat(seed, i) : 8'(8'hC3 + i);
        @(negedge clk);
      end
      hw_next = 1'b0; hw_active = 1'b0; hw_error = bad;
      @(negedge clk); hw_error = 1'b0;
      check(hw_ready == 1'b0, "R3 ready low after receive", int'(hw_ready), 0);
      if (!bad) begin
        m_seed[(m_head + m_cnt) % 2] = seed;
        m_len[(m_head + m_cnt) % 2]  = n;
        m_cnt++;
      end
    end else begin
      int seen = 0;
      for (int k = 0; k < 3; k++) begin
        hw_next = 1'b0;
        @(negedge clk);
        if (hw_ready) seen++;
      end
      check(seen == 0, "R5 ready held low when full", seen, 0);
      hw_active = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic do_tx(bit err, bit expect_pkt, string req);
    int got = 0;
    int bad_at = -1;
    int exp_b = 0;
    int act_b = 0;
    @(negedge clk); hw_ep = 4'd4; hw_active = 1'b1;
    @(negedge clk);
    check(hw_ready == expect_pkt, req, int'(hw_ready), int'(expect_pkt));
    if (!expect_pkt) begin
      hw_active = 1'b0;
      @(negedge clk);
      return;
    end
    @(negedge clk);
    while (hw_ready && got < 600) begin
      if (bad_at < 0 && hw_tx_data != pat(m_seed[m_head], got)) begin
        bad_at = got; act_b = int'(hw_tx_data); exp_b = int'(pat(m_seed[m_head], got));
      end
      got++;
      hw_next = 1'b1;
      @(negedge clk);
    end
    hw_next = 1'b0;
    if (m_len[m_head] == 0)
      check(got == 0, "R8 zero-length single ready clock", got, 0);
    else
      check(got == m_len[m_head], "R7 transmit length", got, m_len[m_head]);
    check(bad_at < 0, "R7 R11 transmit byte content", act_b, exp_b);
    hw_active = 1'b0; hw_error = err;
    @(negedge clk); hw_error = 1'b0;
    if (!err) begin
      m_head = (m_head + 1) % 2;
      m_cnt--;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(hw_ready == 1'b0 && hw_stall == 1'b0, "R1 reset outputs", int'({hw_ready, hw_stall}), 0);
    rst = 1'b0;
    @(negedge clk);
    check(hw_ready == 1'b0 && hw_stall == 1'b0, "R1 after reset", int'({hw_ready, hw_stall}), 0);

    do_tx(1'b0, 1'b0, "R6 empty queue not ready");

    @(negedge clk); hw_ep = 4'd2; hw_active = 1'b1;
    @(negedge clk);
    check(hw_stall == 1'b1 && hw_ready == 1'b0, "R10 stall on other endpoint", int'({hw_stall, hw_ready}), 2);
    hw_active = 1'b0;
    @(negedge clk);
    check(hw_stall == 1'b0, "R10 stall released", int'(hw_stall), 0);

    for (int n = 0; n <= 18; n++) begin
      do_rx(n, n + 3, 1'b0, 1'b1, "R2 receive ready");
      do_tx(1'b0, 1'b1, "R2 transmit ready");
    end
    do_rx(511, 91, 1'b0, 1'b1, "R12 receive ready 511");
    do_tx(1'b0, 1'b1, "R12 transmit ready 511");
    do_rx(512, 92, 1'b0, 1'b1, "R12 receive ready 512");
    do_tx(1'b0, 1'b1, "R12 transmit ready 512");

    do_rx(5, 40, 1'b0, 1'b1, "R11 first packet");
    do_rx(9, 41, 1'b0, 1'b1, "R11 second packet");
    do_rx(6, 42, 1'b0, 1'b0, "R5 full refuses receive");
    do_tx(1'b1, 1'b1, "R9 first send");
    do_tx(1'b0, 1'b1, "R9 resend after error");
    do_tx(1'b0, 1'b1, "R11 second in order");
    do_tx(1'b0, 1'b0, "R6 drained queue not ready");

    do_rx(7, 50, 1'b1, 1'b1, "R4 bad receive accepted");
    do_tx(1'b0, 1'b0, "R4 bad receive not queued");
    do_rx(4, 51, 1'b0, 1'b1, "R4 good receive after bad");
    do_tx(1'b0, 1'b1, "R4 returns good packet");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule